// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block collects every reset request of a small processor core and turns them into a single chip reset that is synchronous to the core clock. It also keeps a byte of cause flags that software reads after a restart to learn what happened. The sources are a power-on detect (the block's own asynchronous reset), a brown-out detector gated by an enable, an active-low external reset pin, a watchdog time-out, a software reset strobe, stack overflow and underflow strobes, and a sleep indicator from the core. The pin is only an input and is never driven by the block.

After power-on the block waits for a power-up delay and then an oscillator start-up delay. The first delay counts rising edges of a separate free-running RC clock. The second counts cycles of the main clock. Every other cause holds the chip in reset only while its synchronized request is present, and releases it on the next cycle. A watchdog time-out while the core sleeps wakes the core and does not reset it. Asynchronous inputs pass through a two-stage synchronizer. The pin also passes through a low-pulse filter.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises until the power-on delays finish, `chip_rst` is 1 and `rst_flags` reads 0x01. The flag bits are: bit0 power-on, bit1 brown-out, bit2 pin, bit3 watchdog, bit4 software, bit5 stack overflow, bit6 stack underflow, bit7 sleep.
- R2: After power-on, `chip_rst` falls only after 2**PWRT_W rising edges of `rc_clk` and then 2**OST_W cycles of `clk`. These two phases are counted one after the other.
- R3: A low pulse on `mclr_n` that lasts fewer than FILT_LEN clock samples causes no reset and leaves the flags unchanged. A low level held for FILT_LEN samples or longer raises `chip_rst`, which stays high while the pin is low. The flags then read 0x04, and `chip_rst` falls a few cycles after the pin returns high.
- R4: An accepted pin reset while `sleep` is 1 loads the flags with 0x84.
- R5: A rising edge of `wdt_to` while `sleep` is 0 resets the chip and loads the flags with 0x08.
- R6: A rising edge of `wdt_to` while `sleep` is 1 does not raise `chip_rst` and loads the flags with 0x88.
- R7: `bor_det` causes a reset only while `bor_en` is 1. That reset loads the flags with 0x02 and holds `chip_rst` while the detect is high. With `bor_en` at 0, `bor_det` has no effect on `chip_rst` or on the flags.
- R8: A one-cycle `sw_rst` strobe makes `chip_rst` high for exactly one cycle and loads the flags with 0x10.
- R9: A one-cycle `stk_full` strobe gives one reset with flags 0x20. A one-cycle `stk_unf` strobe gives one reset with flags 0x40.
- R10: When several causes arrive in the same cycle there is one reset. Its flags name the cause of highest priority, in this order: brown-out, pin, watchdog, software, overflow, underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on detect |
| rc_clk | input | 1 | Free-running RC clock for the power-up delay |
| bor_det | input | 1 | Brown-out detect, asynchronous |
| bor_en | input | 1 | Brown-out reset enable |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_to | input | 1 | Watchdog time-out, asynchronous |
| sleep | input | 1 | Core is in sleep |
| sw_rst | input | 1 | Software reset strobe |
| stk_full | input | 1 | Stack overflow strobe |
| stk_unf | input | 1 | Stack underflow strobe |
| chip_rst | output | 1 | Synchronous active-high chip reset |
| rst_flags | output | 8 | Cause flags of the last event |

## Verification
The bench builds the block with PWRT_W=3 and OST_W=4. A full power-up sequence then takes under a hundred clock cycles, so the bench can bound its exact length and still have room for every other cause. FILT_LEN keeps its default of 4, so the pin pulses of 3 and 4 samples sit on either side of the filter's acceptance edge. The RC clock runs at one eighth of the main clock, which checks that the power-up count follows RC edges and not main-clock cycles.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_PWRT = 2'd0,
    ST_OST  = 2'd1,
    ST_HOLD = 2'd2,
    ST_RUN  = 2'd3
  } rsq_state_e;

  typedef struct packed {
    logic slp;
    logic unf;
    logic ovf;
    logic sw;
    logic wdt;
    logic pin;
    logic brn;
    logic pwr;
  } rsq_flags_t;

  localparam rsq_flags_t FLAGS_POWER_ON = rsq_flags_t'(8'h01);
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_glitch_filter.sv
module rsq_glitch_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_s,
  output logic req
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pin_n_s)             cnt_d = '0;
    else if (cnt_q != LEN_C) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign req = (cnt_q == LEN_C);

  // R3
  filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(!pin_n_s));

  // R3
  filt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_n_s |=> !req);
endmodule

// File: rtl/rsq_delay_cnt.sv
module rsq_delay_cnt #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  logic [W:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                  cnt_d = '0;
    else if (tick && !cnt_q[W]) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = cnt_q[W];

  // R2
  dly_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run && tick));

  // R2
  dly_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int PWRT_W      = 10,
  parameter int OST_W       = 10,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rc_clk,
  input  logic       bor_det,
  input  logic       bor_en,
  input  logic       mclr_n,
  input  logic       wdt_to,
  input  logic       sleep,
  input  logic       sw_rst,
  input  logic       stk_full,
  input  logic       stk_unf,
  output logic       chip_rst,
  output logic [7:0] rst_flags
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

  logic             rst_n;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             rc_s, mclr_s, bor_s, wdt_s;
  logic             rc_q, wdt_q;
  logic             rc_tick, wdt_rise, wdt_req, wdt_wake, bor_req, pin_req, src_any;
  logic             pwrt_done, ost_done;
  rsq_state_e       state_q, state_d;
  rsq_flags_t       flags_q, flags_d, cause_flags;

  rsq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(rst_n));

  assign async_in = {rc_clk, mclr_n, bor_det, wdt_to};

  rsq_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out));

  assign {rc_s, mclr_s, bor_s, wdt_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      rc_q  <= rc_s;
      wdt_q <= wdt_s;
    end
  end

  assign rc_tick  = rc_s & ~rc_q;
  assign wdt_rise = wdt_s & ~wdt_q;
  assign wdt_req  = wdt_rise & ~sleep;
  assign wdt_wake = wdt_rise & sleep;
  assign bor_req  = bor_s & bor_en;

  rsq_glitch_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_n_s(mclr_s), .req(pin_req));

  rsq_delay_cnt #(.W(PWRT_W)) u_pwrt (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_PWRT), .tick(rc_tick),
    .done(pwrt_done));

  rsq_delay_cnt #(.W(OST_W)) u_ost (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_OST), .tick(1'b1),
    .done(ost_done));

  assign src_any = bor_req | pin_req | wdt_req | sw_rst | stk_full | stk_unf;

  always_comb begin
    cause_flags = '0;
    if (bor_req)       cause_flags.brn = 1'b1;
    else if (pin_req) begin
      cause_flags.pin = 1'b1;
      cause_flags.slp = sleep;
    end
    else if (wdt_req)  cause_flags.wdt = 1'b1;
    else if (sw_rst)   cause_flags.sw  = 1'b1;
    else if (stk_full) cause_flags.ovf = 1'b1;
    else               cause_flags.unf = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    flags_d = flags_q;
    case (state_q)
      ST_PWRT: if (pwrt_done) state_d = ST_OST;
      ST_OST:  if (ost_done)  state_d = ST_HOLD;
      ST_HOLD: if (!src_any)  state_d = ST_RUN;
      ST_RUN: begin
        if (src_any) begin
          state_d = ST_HOLD;
          flags_d = cause_flags;
        end else if (wdt_wake) begin
          flags_d     = '0;
          flags_d.wdt = 1'b1;
          flags_d.slp = 1'b1;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRT;
      flags_q <= FLAGS_POWER_ON;
    end else begin
      state_q <= state_d;
      flags_q <= flags_d;
    end
  end

  assign chip_rst  = (state_q != ST_RUN);
  assign rst_flags = flags_q;

  // R5
  enter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && src_any) |=> chip_rst);

  // R6
  wake_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wdt_wake && !src_any) |=> !chip_rst);

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst) |-> $past(!src_any));

  // R2
  ost_after_pwrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OST && $past(state_q) != ST_OST) |-> $past(pwrt_done));

  // R10
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_flags[6:0]));
endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
  localparam int PWRT_W = 3;
  localparam int OST_W  = 4;

  logic clk = 1'b0, rc_clk = 1'b0;
  logic por_n, bor_det, bor_en, mclr_n, wdt_to, sleep, sw_rst, stk_full, stk_unf;
  logic chip_rst;
  logic [7:0] rst_flags;

  int n_chk = 0, n_fail = 0, rise_cnt = 0;
  logic mon_en = 1'b0, prev_rst = 1'b1;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;
  always #40 rc_clk = ~rc_clk;

  rst_seq_ctrl #(.PWRT_W(PWRT_W), .OST_W(OST_W), .FILT_LEN(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .por_n(por_n), .rc_clk(rc_clk), .bor_det(bor_det), .bor_en(bor_en),
    .mclr_n(mclr_n), .wdt_to(wdt_to), .sleep(sleep), .sw_rst(sw_rst),
    .stk_full(stk_full), .stk_unf(stk_unf), .chip_rst(chip_rst), .rst_flags(rst_flags));

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] f, input string rq);
    exp_q.push_back(f);
    tag_q.push_back(rq);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every rising chip_rst pops one expected flag value
  always @(negedge clk) begin
    if (mon_en) begin
      if (chip_rst && !prev_rst) begin
        rise_cnt++;
        if (exp_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL unexpected reset actual=%0h expected=none", rst_flags);
        end else begin
          string t;
          logic [7:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, int'(rst_flags), int'(e));
        end
      end
      prev_rst = chip_rst;
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) sw_rst = 1'b1;
    if (which == 1) stk_full = 1'b1;
    if (which == 2) stk_unf = 1'b1;
    if (which == 3) begin sw_rst = 1'b1; stk_full = 1'b1; end
    @(negedge clk);
    sw_rst = 1'b0; stk_full = 1'b0; stk_unf = 1'b0;
  endtask

  task automatic hold_count(output int hi);
    hi = 0;
    while (chip_rst && hi < 300) begin
      @(negedge clk);
      hi++;
    end
  endtask

  task automatic pin_low(input int n);
    @(negedge clk);
    mclr_n = 1'b0;
    idle(n);
    mclr_n = 1'b1;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi, base;
    por_n = 1'b0; bor_det = 1'b0; bor_en = 1'b0; mclr_n = 1'b1; wdt_to = 1'b0;
    sleep = 1'b0; sw_rst = 1'b0; stk_full = 1'b0; stk_unf = 1'b0;
    idle(4);
    chk("R1 rst during por", int'(chip_rst), 1);
    chk("R1 flags at por", int'(rst_flags), 8'h01);
    por_n = 1'b1;
    idle(30);
    chk("R1 still held", int'(chip_rst), 1);
    chk("R1 flags held", int'(rst_flags), 8'h01);
    hold_count(hi);
    hi += 30;
    // 2**OST_W clk + 2**PWRT_W rc edges at 8 clk each, plus sync slack
    chk("R2 power-up length in range", int'(hi >= 72 && hi <= 110), 1);
    if (!(hi >= 72 && hi <= 110)) $display("  power-up length %0d", hi);
    prev_rst = 1'b0;
    mon_en = 1'b1;
    idle(3);

    // R8 software strobe: one cycle of reset
    push(8'h10, "R8 sw flags");
    strobe(0);
    hold_count(hi);
    chk("R8 sw pulse width", hi, 1);
    idle(3);

    // R9 stack strobes
    push(8'h20, "R9 overflow flags");
    strobe(1);
    idle(5);
    push(8'h40, "R9 underflow flags");
    strobe(2);
    idle(5);

    // R10 simultaneous software + overflow
    base = rise_cnt;
    push(8'h10, "R10 priority flags");
    strobe(3);
    idle(6);
    chk("R10 single reset", rise_cnt - base, 1);

    // R5 watchdog while running
    push(8'h08, "R5 wdt flags");
    @(negedge clk); wdt_to = 1'b1;
    idle(3); wdt_to = 1'b0;
    idle(8);
    chk("R5 released", int'(chip_rst), 0);

    // R6 watchdog while sleeping: wake only
    base = rise_cnt;
    sleep = 1'b1;
    @(negedge clk); wdt_to = 1'b1;
    idle(3); wdt_to = 1'b0;
    idle(8);
    chk("R6 no reset", rise_cnt - base, 0);
    chk("R6 chip_rst low", int'(chip_rst), 0);
    chk("R6 wake flags", int'(rst_flags), 8'h88);
    sleep = 1'b0;
    idle(2);

    // R3 short pulse rejected (3 samples)
    base = rise_cnt;
    pin_low(3);
    idle(10);
    chk("R3 short pulse no reset", rise_cnt - base, 0);
    chk("R3 flags unchanged", int'(rst_flags), 8'h88);

    // R3 boundary pulse accepted (4 samples)
    push(8'h04, "R3 pin flags boundary");
    pin_low(4);
    idle(10);
    chk("R3 boundary accepted", rise_cnt - base, 1);
    chk("R3 released after pin high", int'(chip_rst), 0);

    // R3 long low holds reset
    push(8'h04, "R3 pin flags long");
    @(negedge clk); mclr_n = 1'b0;
    idle(20);
    chk("R3 held while pin low", int'(chip_rst), 1);
    mclr_n = 1'b1;
    idle(8);
    chk("R3 release", int'(chip_rst), 0);

    // R4 pin during sleep
    sleep = 1'b1;
    push(8'h84, "R4 pin sleep flags");
    pin_low(10);
    idle(8);
    sleep = 1'b0;
    chk("R4 released", int'(chip_rst), 0);

    // R7 brown-out disabled: no effect
    base = rise_cnt;
    @(negedge clk); bor_det = 1'b1;
    idle(8); bor_det = 1'b0;
    idle(6);
    chk("R7 disabled no reset", rise_cnt - base, 0);
    chk("R7 disabled flags kept", int'(rst_flags), 8'h84);

    // R7 brown-out enabled
    bor_en = 1'b1;
    push(8'h02, "R7 bor flags");
    @(negedge clk); bor_det = 1'b1;
    idle(10);
    chk("R7 held while detect", int'(chip_rst), 1);
    bor_det = 1'b0;
    idle(8);
    chk("R7 released", int'(chip_rst), 0);

    idle(4);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule